// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves accepted Ethernet frames into host memory using a ring of 16-byte receive descriptors. Software loads a 64-bit ring base through a small configuration port and gives descriptors to the engine by setting their ownership bit. For each frame, an upstream filter first offers a header carrying the frame length and its address class. The engine then reads the four words of the current descriptor and decides whether the frame fits.

When the descriptor is owned and large enough, the engine packs the frame bytes into little-endian 32-bit words and writes them to the buffer. Frames below the minimum size are padded with zero bytes, and four zero bytes stand in for the CRC. The engine then writes back the status word and the tag word, raises a receive-OK pulse and moves to the next descriptor. A frame that cannot be stored is drained from the byte stream without any memory write. In that case the engine pulses the overflow interrupt and counts the frame as missed and as a receive error.

The memory port is word-wide and uses a request/acknowledge pair. A request holds its address, data and strobes until it is acknowledged. Read data is taken in the cycle of the acknowledge.

Top module: `rxring_dma`

## Requirements
- R1: The descriptor for ring index i sits at base + 16*i. Each frame begins with four reads at offsets 0, 4, 8 and 12: word 0 is control/status, word 1 is tag info, and words 2 and 3 are the low and high halves of the buffer address. After reset the index and both base halves are zero, hdr_ready is 1, and no request or interrupt is active.
- R2: If word 0 bit 31 (owned by engine) is clear, the frame is dropped. There is no write, the length's worth of bytes is still consumed, and irq_ovf pulses for one cycle. miss_cnt and err_cnt each rise by one, saturating, and the ring index is unchanged.
- R3: The stored length is the frame length raised to MIN_FRAME. If the stored length + 4 is greater than word 0 bits 12:0, the frame is dropped exactly as in R2. If it is equal, the frame is accepted.
- R4: Stored byte k goes to byte lane k mod 4 of the word at buffer + 4*(k div 4), with mem_wstrb marking the lanes written. Unwritten lanes carry zero. Buffers are 4-byte aligned.
- R5: A frame shorter than MIN_FRAME bytes is followed by zero bytes up to MIN_FRAME.
- R6: Four zero bytes follow the stored frame, standing in for the CRC.
- R7: After the data, word 0 is written back with bit 31 cleared and bits 29 and 28 set. Bit 26 is ORed with multicast (hdr_kind[1]), bit 25 with own-address match (hdr_kind[0]) and bit 24 with broadcast (hdr_kind[2]). Bits 12:0 become the stored length + 4. All other bits keep their read value.
- R8: Word 1 is then written back with bit 16 cleared and all other bits as read.
- R9: After write-back, the index returns to 0 if word 0 bit 30 was set, and otherwise increments.
- R10: irq_rxok pulses for one cycle only after the word 1 write is acknowledged. hdr_ready stays low from header acceptance until then.
- R11: cfg_we with cfg_hi=0 loads base bits 31:0, and with cfg_hi=1 loads base bits 63:32. Descriptor addresses use the full 64-bit base, and buffer addresses use the full 64-bit word 3:word 2 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Ring base write strobe |
| cfg_hi | input | 1 | Selects the upper (1) or lower (0) base half |
| cfg_wdata | input | 32 | Base half value |
| hdr_valid | input | 1 | Frame header offered |
| hdr_ready | output | 1 | Engine idle and able to take a header |
| hdr_len | input | 13 | Frame length in bytes |
| hdr_kind | input | 3 | {broadcast, multicast, own-address match} |
| byte_valid | input | 1 | Frame byte offered |
| byte_ready | output | 1 | Engine takes the byte this cycle |
| byte_data | input | 8 | Frame byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_wstrb | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq_ovf | output | 1 | One-cycle pulse on a dropped frame |
| irq_rxok | output | 1 | One-cycle pulse on a stored frame |
| miss_cnt | output | CNT_W | Saturating missed-frame count |
| err_cnt | output | CNT_W | Saturating receive-error count |

## Verification
A wrong ring index or base shows up at the first read address of the next frame, within a cycle of the header being taken. A miscounted byte position shows up as wrong lane data, wrong strobes or a wrong word address on the first data write after the fault, and as a wrong length in the status write-back. A bad ownership or capacity decision appears within a few cycles of the fourth descriptor read. Depending on the fault, it shows as a data write where none is expected, a missing write, or an overflow pulse and counter step where a receive-OK pulse belongs.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_RDESC = 3'd1,
        S_FILL  = 3'd2,
        S_WDAT  = 3'd3,
        S_WB0   = 3'd4,
        S_WB1   = 3'd5,
        S_SKIP  = 3'd6
    } rx_state_e;

    // descriptor word 0 / word 1 bit positions (fixed by the ring layout)
    localparam int OWN_B = 31;
    localparam int EOR_B = 30;
    localparam int FS_B  = 29;
    localparam int LS_B  = 28;
    localparam int MC_B  = 26;
    localparam int PM_B  = 25;
    localparam int BC_B  = 24;
    localparam int TAG_B = 16;
    localparam int SZ_W  = 13;
endpackage

// File: rtl/rxring_status.sv
module rxring_status
    import rxring_pkg::*;
(
    input  logic [31:0]   dw0_in,
    input  logic [31:0]   dw1_in,
    input  logic [2:0]    kind,
    input  logic [SZ_W:0] tot,
    output logic [31:0]   wb0,
    output logic [31:0]   wb1
);
    always_comb begin
        wb0           = dw0_in;
        wb0[OWN_B]    = 1'b0;
        wb0[FS_B]     = 1'b1;
        wb0[LS_B]     = 1'b1;
        wb0[PM_B]     = dw0_in[PM_B] | kind[0];
        wb0[MC_B]     = dw0_in[MC_B] | kind[1];
        wb0[BC_B]     = dw0_in[BC_B] | kind[2];
        wb0[SZ_W-1:0] = tot[SZ_W-1:0];
        wb1           = dw1_in;
        wb1[TAG_B]    = 1'b0;
    end
endmodule

// File: rtl/rxring_sat_cnt.sv
module rxring_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (inc && cnt != '1)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma
    import rxring_pkg::*;
#(
    parameter int IDX_W     = 16,
    parameter int MIN_FRAME = 60,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_hi,
    input  logic [31:0]      cfg_wdata,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [12:0]      hdr_len,
    input  logic [2:0]       hdr_kind,
    input  logic             byte_valid,
    output logic             byte_ready,
    input  logic [7:0]       byte_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [63:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_wstrb,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             irq_ovf,
    output logic             irq_rxok,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [CNT_W-1:0] err_cnt
);
    localparam int LEN_W = SZ_W;
    localparam int TOT_W = SZ_W + 1;
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    typedef struct packed {
        rx_state_e        st;
        logic [1:0]       rsel;
        logic [IDX_W-1:0] idx;
        logic [63:0]      base;
        logic [LEN_W-1:0] len;
        logic [TOT_W-1:0] tot;
        logic [TOT_W-1:0] pos;
        logic [31:0]      wbuf;
        logic [3:0]       strb;
        logic [31:0]      dw0;
        logic [31:0]      dw1;
        logic [31:0]      dw2;
        logic [31:0]      dw3;
        logic [2:0]       kind;
        logic             ovf;
        logic             rxok;
    } regs_t;

    regs_t q, d;
    logic             drop;
    logic [63:0]      desc_addr;
    logic [63:0]      buf_addr;
    logic [LEN_W-1:0] plen;
    logic [TOT_W-1:0] pm1;
    logic [1:0]       lane;
    logic             need_in;
    logic [31:0]      wb0, wb1;

    rxring_status u_status (
        .dw0_in (q.dw0),
        .dw1_in (q.dw1),
        .kind   (q.kind),
        .tot    (q.tot),
        .wb0    (wb0),
        .wb1    (wb1)
    );

    rxring_sat_cnt #(.W(CNT_W)) u_miss (.clk(clk), .rst_n(rst_n), .inc(drop), .cnt(miss_cnt));
    rxring_sat_cnt #(.W(CNT_W)) u_err  (.clk(clk), .rst_n(rst_n), .inc(drop), .cnt(err_cnt));

    always_comb begin
        d          = q;
        d.ovf      = 1'b0;
        d.rxok     = 1'b0;
        drop       = 1'b0;
        hdr_ready  = 1'b0;
        byte_ready = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_wstrb  = '0;
        desc_addr  = q.base + 64'({q.idx, 4'b0000});
        buf_addr   = {q.dw3, q.dw2};
        plen       = (hdr_len < MIN_L) ? MIN_L : hdr_len;
        pm1        = q.pos - 1'b1;
        lane       = q.pos[1:0];
        need_in    = q.pos < {1'b0, q.len};

        if (cfg_we) begin
            if (cfg_hi) d.base[63:32] = cfg_wdata;
            else        d.base[31:0]  = cfg_wdata;
        end

        case (q.st)
            S_IDLE: begin
                hdr_ready = 1'b1;
                if (hdr_valid) begin
                    d.len  = hdr_len;
                    d.kind = hdr_kind;
                    d.tot  = {1'b0, plen} + TOT_W'(4);
                    d.rsel = 2'd0;
                    d.st   = S_RDESC;
                end
            end
            S_RDESC: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + 64'({q.rsel, 2'b00});
                if (mem_ack) begin
                    case (q.rsel)
                        2'd0:    d.dw0 = mem_rdata;
                        2'd1:    d.dw1 = mem_rdata;
                        2'd2:    d.dw2 = mem_rdata;
                        default: d.dw3 = mem_rdata;
                    endcase
                    d.rsel = q.rsel + 1'b1;
                    d.pos  = '0;
                    d.wbuf = '0;
                    d.strb = '0;
                    if (q.rsel == 2'd3) begin
                        if (!q.dw0[OWN_B] || (q.tot > {1'b0, q.dw0[SZ_W-1:0]})) begin
                            drop  = 1'b1;
                            d.ovf = 1'b1;
                            d.st  = (q.len == '0) ? S_IDLE : S_SKIP;
                        end else begin
                            d.st  = S_FILL;
                        end
                    end
                end
            end
            S_FILL: begin
                byte_ready = need_in;
                if (!need_in || byte_valid) begin
                    d.wbuf[8*int'(lane) +: 8] = need_in ? byte_data : 8'h00;
                    d.strb[lane]              = 1'b1;
                    d.pos                     = q.pos + 1'b1;
                    if (lane == 2'd3 || (q.pos + 1'b1) == q.tot) d.st = S_WDAT;
                end
            end
            S_WDAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_addr + 64'({pm1[TOT_W-1:2], 2'b00});
                mem_wdata = q.wbuf;
                mem_wstrb = q.strb;
                if (mem_ack) begin
                    d.wbuf = '0;
                    d.strb = '0;
                    d.st   = (q.pos == q.tot) ? S_WB0 : S_FILL;
                end
            end
            S_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr;
                mem_wdata = wb0;
                mem_wstrb = 4'hF;
                if (mem_ack) d.st = S_WB1;
            end
            S_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + 64'd4;
                mem_wdata = wb1;
                mem_wstrb = 4'hF;
                if (mem_ack) begin
                    d.idx  = q.dw0[EOR_B] ? '0 : q.idx + 1'b1;
                    d.rxok = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_SKIP: begin
                byte_ready = 1'b1;
                if (byte_valid) begin
                    d.pos = q.pos + 1'b1;
                    if ((q.pos + 1'b1) == {1'b0, q.len}) d.st = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_ovf  = q.ovf;
    assign irq_rxok = q.rxok;
endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_ready,
    input logic             byte_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic             irq_ovf,
    input logic             irq_rxok,
    input logic [CNT_W-1:0] miss_cnt
);
    assert_rxok_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxok |-> $past(mem_req && mem_we && mem_ack));

    assert_hold_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !hdr_ready);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rxok |=> !irq_rxok);

    assert_no_both_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ovf && irq_rxok));

    assert_miss_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf && $past(miss_cnt) != {CNT_W{1'b1}}) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

    assert_bytes_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> !mem_req);
endmodule

bind rxring_dma rxring_dma_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_ready  (hdr_ready),
    .byte_ready (byte_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .irq_ovf    (irq_ovf),
    .irq_rxok   (irq_rxok),
    .miss_cnt   (miss_cnt)
);

// File: tb/rxring_dma_bench.sv
`timescale 1ns/1ps
module rxring_dma_bench;
    localparam int CNT_W = 16;
    localparam int MINF  = 60;
    localparam int WD    = 50000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0, cfg_hi = 1'b0;
    logic [31:0]      cfg_wdata = '0;
    logic             hdr_valid = 1'b0, hdr_ready;
    logic [12:0]      hdr_len = '0;
    logic [2:0]       hdr_kind = '0;
    logic             byte_valid = 1'b0, byte_ready;
    logic [7:0]       byte_data = '0;
    logic             mem_req, mem_we, mem_ack;
    logic [63:0]      mem_addr;
    logic [31:0]      mem_wdata, mem_rdata;
    logic [3:0]       mem_wstrb;
    logic             irq_ovf, irq_rxok;
    logic [CNT_W-1:0] miss_cnt, err_cnt;

    logic [31:0] mem [0:1023];
    logic [1:0]  ack_cnt = '0;

    always #2 clk = ~clk;
    always @(posedge clk) ack_cnt <= ack_cnt + 1'b1;
    assign mem_ack   = mem_req && (ack_cnt != 2'd3);
    assign mem_rdata = mem[mem_addr[11:2]];

    rxring_dma #(.MIN_FRAME(MINF), .CNT_W(CNT_W)) u_rxring_dma (.*);

    typedef struct packed {
        logic        we;
        logic [63:0] addr;
        logic [31:0] data;
        logic [3:0]  strb;
        logic [7:0]  rq;
    } item_t;

    item_t exp_q[$];
    int n_cmp = 0, n_bad = 0;
    int got_ok = 0, got_ovf = 0, exp_ok = 0, exp_ovf = 0, exp_miss = 0;

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int seed, input int k);
        return 8'(seed + k * 13 + 1);
    endfunction

    task automatic set_desc(input logic [11:0] a, input logic [31:0] w0, w1, w2, w3);
        mem[a[11:2]]      = w0;
        mem[a[11:2] + 1]  = w1;
        mem[a[11:2] + 2]  = w2;
        mem[a[11:2] + 3]  = w3;
    endtask

    // scoreboard monitor: compares every acknowledged memory access
    task automatic monitor();
        item_t it;
        forever begin
            @(negedge clk);
            if (irq_rxok) got_ok++;
            if (irq_ovf)  got_ovf++;
            if (mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(0, 2, "unexpected memory access (dropped frame must not write)", mem_addr, 64'hx);
                end else begin
                    it = exp_q.pop_front();
                    chk(mem_we == it.we && mem_addr == it.addr, it.rq, "access kind/address",
                        {mem_we, mem_addr[62:0]}, {it.we, it.addr[62:0]});
                    if (it.we)
                        chk(mem_wdata == it.data && mem_wstrb == it.strb, it.rq, "write data/strobe",
                            {28'h0, mem_wstrb, mem_wdata}, {28'h0, it.strb, it.data});
                end
                if (mem_we)
                    for (int b = 0; b < 4; b++)
                        if (mem_wstrb[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end
        end
    endtask

    task automatic run_frame(input int len, input logic [2:0] kind, input int seed,
                             input logic [63:0] dsc, input bit ok_exp);
        item_t it;
        logic [31:0] w0, w1, e0;
        logic [63:0] bufa;
        int plen, tot, nw;
        w0   = mem[dsc[11:2]];
        w1   = mem[dsc[11:2] + 1];
        bufa = {mem[dsc[11:2] + 3], mem[dsc[11:2] + 2]};
        plen = (len < MINF) ? MINF : len;      // R5 padding
        tot  = plen + 4;                        // R6 zero CRC bytes
        nw   = (tot + 3) / 4;
        // R1: four descriptor reads
        for (int r = 0; r < 4; r++) begin
            it = '0; it.we = 1'b0; it.addr = dsc + 64'(4 * r); it.rq = 8'd1;
            exp_q.push_back(it);
        end
        if (ok_exp) begin
            // R4: byte packing
            for (int j = 0; j < nw; j++) begin
                it = '0; it.we = 1'b1; it.addr = bufa + 64'(4 * j); it.rq = 8'd4;
                for (int b = 0; b < 4; b++) begin
                    int k = 4 * j + b;
                    if (k < tot) it.strb[b] = 1'b1;
                    if (k < len) it.data[8*b +: 8] = fbyte(seed, k);
                end
                exp_q.push_back(it);
            end
            // R7: status write-back
            e0 = w0; e0[31] = 1'b0; e0[29] = 1'b1; e0[28] = 1'b1;
            e0[26] = w0[26] | kind[1]; e0[25] = w0[25] | kind[0]; e0[24] = w0[24] | kind[2];
            e0[12:0] = 13'(tot);
            it = '0; it.we = 1'b1; it.addr = dsc; it.data = e0; it.strb = 4'hF; it.rq = 8'd7;
            exp_q.push_back(it);
            // R8: tag word write-back
            it = '0; it.we = 1'b1; it.addr = dsc + 64'd4; it.data = w1 & ~32'h0001_0000;
            it.strb = 4'hF; it.rq = 8'd8;
            exp_q.push_back(it);
            exp_ok++;
        end else begin
            exp_ovf++;
            exp_miss++;
        end
        @(negedge clk);
        hdr_valid = 1'b1; hdr_len = 13'(len); hdr_kind = kind;
        while (!hdr_ready) @(negedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        for (int k = 0; k < len; k++) begin
            byte_valid = 1'b1; byte_data = fbyte(seed, k);
            while (!byte_ready) @(negedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        while (!(hdr_ready && exp_q.size() == 0)) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, 4, "pending expected accesses", 64'(exp_q.size()), 0);
        chk(got_ok == exp_ok, 10, "receive-OK pulse count", 64'(got_ok), 64'(exp_ok));
        chk(got_ovf == exp_ovf, 2, "overflow pulse count", 64'(got_ovf), 64'(exp_ovf));
        chk(miss_cnt == CNT_W'(exp_miss) && err_cnt == CNT_W'(exp_miss), 3, "miss/err counters",
            {32'(miss_cnt), 32'(err_cnt)}, {32'(exp_miss), 32'(exp_miss)});
    endtask

    task automatic cfg_write(input bit hi, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_hi = hi; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_tests();
        // R1: reset state
        chk(hdr_ready == 1'b1 && mem_req == 1'b0 && !irq_ovf && !irq_rxok, 1, "reset outputs",
            {60'h0, hdr_ready, mem_req, irq_ovf, irq_rxok}, 64'h8);
        chk(miss_cnt == '0 && err_cnt == '0, 1, "reset counters", 64'(miss_cnt), 0);
        // R11: base low half
        cfg_write(1'b0, 32'h0000_0100);
        // A: index 0, multicast, short frame padded (R5), tag bit cleared (R8)
        set_desc(12'h100, 32'h8010_0600, 32'h0001_ABCD, 32'h0000_0200, 32'h0);
        run_frame(10, 3'b010, 5, 64'h100, 1'b1);
        // B: index 1, broadcast, 61 bytes, odd tail strobes (R4)
        set_desc(12'h110, 32'h8000_00C8, 32'h0000_0001, 32'h0000_0300, 32'h0);
        run_frame(61, 3'b100, 9, 64'h110, 1'b1);
        // C: index 2 owned by host -> dropped (R2)
        set_desc(12'h120, 32'h0000_01F4, 32'h0, 32'h0000_0400, 32'h0);
        run_frame(20, 3'b001, 3, 64'h120, 1'b0);
        // D: index unchanged; 59 bytes pad to 60, needs 64 > 63 -> dropped (R3)
        set_desc(12'h120, 32'h8000_003F, 32'h0, 32'h0000_0400, 32'h0);
        run_frame(59, 3'b001, 3, 64'h120, 1'b0);
        // E: exact fit 64 with end-of-ring set (R3, R9)
        set_desc(12'h120, 32'hC000_0040, 32'h0003_0000, 32'h0000_0400, 32'h0);
        run_frame(59, 3'b001, 7, 64'h120, 1'b1);
        // F: wrapped to index 0 with upper base half and 64-bit buffer (R9, R11)
        cfg_write(1'b1, 32'h0000_0005);
        set_desc(12'h100, 32'h8000_0600, 32'h0, 32'h0000_0500, 32'h0000_0007);
        run_frame(70, 3'b000, 11, 64'h0000_0005_0000_0100, 1'b1);
        // R6: CRC bytes of frame A read back from memory are zero
        chk(mem[(12'h200 + 12'd60) >> 2] == 32'h0, 6, "zero CRC word in buffer",
            64'(mem[(12'h200 + 12'd60) >> 2]), 0);
        // R5: padding byte of frame A in memory is zero
        chk(mem[(12'h200 + 12'd12) >> 2] == 32'h0, 5, "zero pad word in buffer",
            64'(mem[(12'h200 + 12'd12) >> 2]), 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            monitor();
            run_tests();
            begin
                repeat (WD) @(posedge clk);
                @(negedge clk);
                chk(0, 10, "watchdog expired", 64'(WD), 0);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule